// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

The block is an N-bit arithmetic and logic unit made from one 1-bit slice per bit position. Every slice gets one bit of each operand. It produces the AND, the OR or the full-adder sum of those bits, and passes its carry on to the slice above it. A two-bit select is shared by all slices and picks which slice output appears on the result word. A shared invert control complements the B operand inside every slice before any of the three functions sees it.

The carry into bit 0 is tied to the invert control. With select at 2, clearing invert gives A + B. Setting invert gives A + ~B + 1, which is A − B in two's complement. The carry out of the top slice is a port of its own. The unit has no clock or storage: results follow the operands after the ripple through all N slices has settled. The default width is 32 bits.

Top module: `rca_alu`

## Requirements
- R1: With sel = 0, result equals op_a AND b', where b' is op_b when inv = 0 and NOT op_b when inv = 1.
- R2: With sel = 1, result equals op_a OR b', with b' as in R1.
- R3: With sel = 2 and inv = 0, result equals (op_a + op_b) mod 2^W, and carry_out is bit W of the unsigned sum.
- R4: With sel = 2 and inv = 1, result equals (op_a − op_b) mod 2^W, and carry_out is 1 exactly when op_a ≥ op_b as unsigned numbers.
- R5: With sel = 3, result is all zeros whatever the operands and invert are.
- R6: For every sel value, carry_out equals bit W of op_a + b' + inv. The carry chain does not depend on the select.
- R7: After reset, with all operand and control inputs at 0, result and carry_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | Operand A |
| op_b | input | W | Operand B, complemented in every slice when inv is 1 |
| sel | input | 2 | Slice function: 0 AND, 1 OR, 2 sum, 3 zero |
| inv | input | 1 | Complements B and is also the carry into bit 0 |
| result | output | W | Selected slice outputs |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
Both result and carry_out are combinational, so each is due in the same cycle as the operands and controls that produce it. No register stands in the path. The bench changes the inputs just after a rising clock edge and compares the outputs at the next falling edge, half a period later. That gives the full ripple chain time to settle before sampling, and keeps the sampling point away from the edge where the inputs change. Expected values come from a behavioural model that uses whole-word operators.

// File: rtl/rca_alu.sv
module rca_slice (
  input  logic       a,
  input  logic       b,
  input  logic       inv,
  input  logic       cin,
  input  logic [1:0] sel,
  output logic       res,
  output logic       cout
);
  logic b_eff;
  logic hs1, hc1, hs2, hc2;

  assign b_eff = b ^ inv;

  assign hs1 = a ^ b_eff;
  assign hc1 = a & b_eff;

  assign hs2 = hs1 ^ cin;
  assign hc2 = hs1 & cin;

  assign cout = hc1 | hc2;

  always_comb begin
    case (sel)
      2'd0:    res = a & b_eff;
      2'd1:    res = a | b_eff;
      2'd2:    res = hs2;
      default: res = 1'b0;
    endcase
  end
endmodule

module rca_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   sel,
  input  logic         inv,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic [W:0] chain;

  assign chain[0] = inv;

  for (genvar i = 0; i < W; i++) begin : g_bit
    rca_slice u_slice (
      .a    (op_a[i]),
      .b    (op_b[i]),
      .inv  (inv),
      .cin  (chain[i]),
      .sel  (sel),
      .res  (result[i]),
      .cout (chain[i+1])
    );
  end

  assign carry_out = chain[W];
endmodule

module rca_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [1:0]   sel,
  input logic         inv,
  input logic [W-1:0] result,
  input logic         carry_out
);
  logic [W-1:0] bx;
  logic [W:0]   wsum;

  always_comb begin
    bx   = inv ? ~op_b : op_b;
    wsum = {1'b0, op_a} + {1'b0, bx} + {{W{1'b0}}, inv};

    // R1
    and_res_chk: assert (sel != 2'd0 || result == (op_a & bx))
      else $error("and result mismatch");
    // R2
    or_res_chk: assert (sel != 2'd1 || result == (op_a | bx))
      else $error("or result mismatch");
    // R3
    add_res_chk: assert (sel != 2'd2 || inv || {carry_out, result} == {1'b0, op_a} + {1'b0, op_b})
      else $error("add mismatch");
    // R4
    sub_res_chk: assert (sel != 2'd2 || !inv || (result == op_a - op_b && carry_out == (op_a >= op_b)))
      else $error("sub mismatch");
    // R5
    zero_res_chk: assert (sel != 2'd3 || result == '0)
      else $error("reserved select not zero");
    // R6
    carry_chk: assert (carry_out == wsum[W])
      else $error("carry out mismatch");
  end
endmodule

bind rca_alu rca_alu_chk #(.W(W)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .sel       (sel),
  .inv       (inv),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/tb_rca_alu.sv
`timescale 1ns/1ps
module tb_rca_alu;
  localparam int W = 32;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0]   sel = 2'd0;
  logic         inv = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rca_alu #(.W(W)) dut (
    .op_a(op_a), .op_b(op_b), .sel(sel), .inv(inv),
    .result(result), .carry_out(carry_out)
  );

  // {a, b, sel, inv}
  localparam logic [2*W+2:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 2'd2, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 2'd2, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 2'd2, 1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b0},
    {32'h0000_0005, 32'h0000_0005, 2'd2, 1'b1},
    {32'h0000_0000, 32'h0000_0001, 2'd2, 1'b1},
    {32'h8000_0000, 32'h0000_0001, 2'd2, 1'b1},
    {32'h0000_0001, 32'hFFFF_FFFF, 2'd2, 1'b1},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 1'b0},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 1'b1},
    {32'h0F0F_0F0F, 32'h00FF_00FF, 2'd1, 1'b0},
    {32'h0F0F_0F0F, 32'h00FF_00FF, 2'd1, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 2'd3, 1'b1}
  };

  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                       logic [1:0] s, logic iv);
    logic [W-1:0] bb, r;
    logic [W:0]   t;
    bb = iv ? ~b : b;
    t  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, iv};
    case (s)
      2'd0:    r = a & bb;
      2'd1:    r = a | bb;
      2'd2:    r = t[W-1:0];
      default: r = '0;
    endcase
    return {t[W], r};
  endfunction

  function automatic string tag_of(logic [1:0] s, logic iv);
    case (s)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return iv ? "R4" : "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] s, logic iv);
    logic [W:0] exp;
    @(posedge clk);
    #0.5;
    op_a = a; op_b = b; sel = s; inv = iv;
    @(negedge clk);
    exp = model(a, b, s, iv);
    checks++;
    if (result !== exp[W-1:0]) begin
      errors++;
      $display("FAIL %s result a=%h b=%h sel=%0d inv=%0d actual %h expected %h",
               tag_of(s, iv), a, b, s, iv, result, exp[W-1:0]);
    end
    checks++;
    if (carry_out !== exp[W]) begin
      errors++;
      $display("FAIL R6 carry a=%h b=%h sel=%0d inv=%0d actual %0d expected %0d",
               a, b, s, iv, carry_out, exp[W]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== '0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset actual %h/%0d expected 0/0", result, carry_out);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(VEC[i][2*W+2:W+3], VEC[i][W+2:3], VEC[i][2:1], VEC[i][0]);

    // R6: same operands, every select, carry must not move
    for (int s = 0; s < 4; s++) begin
      apply(32'h8000_0001, 32'h8000_0000, 2'(s), 1'b0);
      apply(32'h0000_0003, 32'h0000_0007, 2'(s), 1'b1);
    end

    for (int i = 0; i < 400; i++)
      apply($urandom, $urandom, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule